// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer with Mode Bit-OR Dispatch

This block holds the microprogram counter (uPC) of a microcoded control unit and computes the next control-store address. A microword that is not a branch advances the counter by one. A branch microword loads a base address taken from the microword. Before the load, selected instruction-register bits can be ORed into fixed low-order bit positions of that base. As a result, one branch word can fan out to several microroutine variants, chosen by the addressing-mode bits of the current instruction, without a full decode table.

There are three independent OR-enable fields in the microword:
- The mode field ORs IR bit 10 into address bit 5 and IR bit 9 into address bit 4.
- The group field ORs IR bit 8 into address bit 3.
- The fine field ORs IR bit 8 into address bit 0.

A typical use is a dispatch after instruction fetch from base octal 101 with the mode and group fields enabled. A later branch from base octal 170 with the fine field enabled then selects word 170 or word 171. This lets one addressing mode skip word 170 and continue at 171.

The control store is outside the block. Control pins are plain levels and have no handshake. The `step` input is the only flow control: while it is low, the counter holds and the other inputs are ignored. Nothing at the block's edge can apply back-pressure.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `upc` is cleared to octal 000, and it reads 000 after reset is released.
- R2: On a clock edge with `step`=1 and `is_branch`=0, `upc` becomes `upc`+1, wrapping from all-ones to zero.
- R3: On a clock edge with `step`=0, `upc` keeps its value whatever the other inputs are.
- R4: On a clock edge with `step`=1, `is_branch`=1 and `or_en`=3'b000, `upc` becomes `base_addr` unchanged.
- R5: When `or_en[0]` (the mode field) is 1 on a branch, IR bit 10 is ORed into address bit 5 and IR bit 9 is ORed into address bit 4.
- R6: When `or_en[1]` (the group field) is 1 on a branch, IR bit 8 is ORed into address bit 3.
- R7: When `or_en[2]` (the fine field) is 1 on a branch, IR bit 8 is ORed into address bit 0.
- R8: On a branch, each enable field alters only its own target bits. ORing never clears a base bit. Bits outside {5,4,3,0} always equal the base.
- R9: A branch from octal 170 with only the fine field enabled lands on 171 when IR bit 8 is 1 and on 170 when it is 0. From 171 a non-branch step reaches 172.
- R10: IR bits other than 10, 9 and 8 have no effect on the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance enable; the counter holds when low |
| is_branch | input | 1 | Current microword is a branch |
| base_addr | input | AW | Branch base address from the microword |
| or_en | input | 3 | OR-enable fields: [0] mode, [1] group, [2] fine |
| ir | input | IRW | Instruction register contents |
| upc | output | AW | Registered microprogram counter |

## Verification
Faults in this block can show up in two ways.
- A wrong lane (source bit, target bit, or enable field) shows at `upc` one clock after the branch edge. It appears as a single-bit error against the base ORed with the expected IR bits. The bench therefore drives each field alone, drives all fields together, and drives IR patterns with unrelated bits set.
- A counter fault, such as a failed hold, a lost increment or a wrong wrap, shows one edge later as an off-by-one value. That error then persists through every following increment. The bench steps across the all-ones wrap point and holds with `step` low while the other inputs toggle.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // Number of OR lanes and OR-enable fields
  localparam int NLANE = 4;
  localparam int NFLD  = 3;

  // Lane table: IR source bit, address target bit, controlling field
  function automatic int lane_src(input int i);
    case (i)
      0: return 10;
      1: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic int lane_dst(input int i);
    case (i)
      0: return 5;
      1: return 4;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int lane_fld(input int i);
    case (i)
      0, 1: return 0;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  // Mask of all address bits any lane may set
  function automatic logic [31:0] touch_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NLANE; i++) m[lane_dst(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/useq_or_lane.sv
module useq_or_lane #(
  parameter int AW  = 8,
  parameter int IRW = 16,
  parameter int SRC = 8,
  parameter int DST = 0
) (
  input  logic           en,
  input  logic [IRW-1:0] ir,
  output logic [AW-1:0]  contrib
);
  localparam logic [AW-1:0] BIT = AW'(1) << DST;

  always_comb begin
    contrib = (en && ir[SRC]) ? BIT : '0;
  end
endmodule

// File: rtl/useq_modifier.sv
module useq_modifier
  import useq_pkg::*;
#(
  parameter int AW  = 8,
  parameter int IRW = 16
) (
  input  logic [AW-1:0]   base_addr,
  input  logic [NFLD-1:0] or_en,
  input  logic [IRW-1:0]  ir,
  output logic [AW-1:0]   mod_addr
);
  logic [AW-1:0] lane_c [NLANE];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    useq_or_lane #(
      .AW (AW),
      .IRW(IRW),
      .SRC(lane_src(g)),
      .DST(lane_dst(g))
    ) u_lane (
      .en     (or_en[lane_fld(g)]),
      .ir     (ir),
      .contrib(lane_c[g])
    );
  end

  always_comb begin
    mod_addr = base_addr;
    for (int i = 0; i < NLANE; i++) mod_addr = mod_addr | lane_c[i];
  end
endmodule

// File: rtl/useq_upc_reg.sv
module useq_upc_reg #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] upc
);
  always_ff @(posedge clk) begin
    if (!rst_n)    upc <= '0;
    else if (step) upc <= load ? load_addr : upc + AW'(1);
  end

  // R2: a non-load step advances by exactly one, wrapping
  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (upc == $past(upc) + AW'(1)));

  // R3: no step, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(upc));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW  = 8,
  parameter int IRW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            is_branch,
  input  logic [AW-1:0]   base_addr,
  input  logic [NFLD-1:0] or_en,
  input  logic [IRW-1:0]  ir,
  output logic [AW-1:0]   upc
);
  localparam logic [AW-1:0] TOUCH = AW'(touch_mask());

  logic [AW-1:0] mod_addr;

  useq_modifier #(.AW(AW), .IRW(IRW)) u_mod (
    .base_addr(base_addr),
    .or_en    (or_en),
    .ir       (ir),
    .mod_addr (mod_addr)
  );

  useq_upc_reg #(.AW(AW)) u_upc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (is_branch),
    .load_addr(mod_addr),
    .upc      (upc)
  );

  // R4: disabled fields pass the base through unchanged
  a_r4_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_branch && (or_en == '0)) |=> (upc == $past(base_addr)));

  // R8: ORing never clears a base bit
  a_r8_keep_base: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_branch) |=> ((upc & $past(base_addr)) == $past(base_addr)));

  // R8: bits outside the lane targets never move away from the base
  a_r8_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_branch) |=> (((upc ^ $past(base_addr)) & ~TOUCH) == '0));
endmodule

// File: tb/useq_top_bench.sv
module useq_top_bench;
  localparam int AW  = 8;
  localparam int IRW = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           step = 1'b0;
  logic           is_branch = 1'b0;
  logic [AW-1:0]  base_addr = '0;
  logic [2:0]     or_en = '0;
  logic [IRW-1:0] ir = '0;
  logic [AW-1:0]  upc;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  useq_top #(.AW(AW), .IRW(IRW)) u_useq_top (
    .clk(clk), .rst_n(rst_n), .step(step), .is_branch(is_branch),
    .base_addr(base_addr), .or_en(or_en), .ir(ir), .upc(upc)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_checks++;
    if (upc !== exp) begin
      n_fail++;
      $display("FAIL %s: upc=%o expected=%o", req, upc, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, sample at the next negedge
  task automatic cyc(input logic s, input logic b, input logic [AW-1:0] a,
                     input logic [2:0] e, input logic [IRW-1:0] r);
    step = s; is_branch = b; base_addr = a; or_en = e; ir = r;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(1'b1, 1'b1, 8'o377, 3'b111, '1);
    check("R1 in reset", 8'o000);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 8'o000, 3'b000, '0);
    check("R1 after release", 8'o000);
  endtask

  task automatic t_increment();
    cyc(1'b1, 1'b1, 8'o122, 3'b000, '0);
    check("R4 plain load 122", 8'o122);
    cyc(1'b1, 1'b0, 8'o000, 3'b000, '0);
    check("R2 increment 123", 8'o123);
    cyc(1'b1, 1'b1, 8'o377, 3'b000, '0);
    check("R4 plain load 377", 8'o377);
    cyc(1'b1, 1'b0, 8'o000, 3'b000, '0);
    check("R2 wrap to 000", 8'o000);
  endtask

  task automatic t_hold();
    cyc(1'b1, 1'b1, 8'o055, 3'b000, '0);
    cyc(1'b0, 1'b1, 8'o377, 3'b111, '1);
    check("R3 hold vs branch", 8'o055);
    cyc(1'b0, 1'b0, 8'o000, 3'b000, '0);
    check("R3 hold vs increment", 8'o055);
  endtask

  task automatic t_dispatch();
    cyc(1'b1, 1'b1, 8'o101, 3'b001, 16'h0400);
    check("R5 IR10 to bit5", 8'o141);
    cyc(1'b1, 1'b1, 8'o101, 3'b001, 16'h0200);
    check("R5 IR9 to bit4", 8'o121);
    cyc(1'b1, 1'b1, 8'o101, 3'b010, 16'h0100);
    check("R6 IR8 to bit3", 8'o111);
    cyc(1'b1, 1'b1, 8'o101, 3'b011, 16'h0700);
    check("R5 R6 full dispatch", 8'o171);
    cyc(1'b1, 1'b1, 8'o100, 3'b100, 16'h0100);
    check("R7 IR8 to bit0", 8'o101);
  endtask

  task automatic t_isolation();
    cyc(1'b1, 1'b1, 8'o101, 3'b000, 16'h0700);
    check("R4 fields off ignore IR", 8'o101);
    cyc(1'b1, 1'b1, 8'o100, 3'b100, 16'h0600);
    check("R8 fine ignores IR10 IR9", 8'o100);
    cyc(1'b1, 1'b1, 8'o100, 3'b001, 16'h0100);
    check("R8 mode ignores IR8", 8'o100);
    cyc(1'b1, 1'b1, 8'o161, 3'b001, 16'h0000);
    check("R8 base bits kept", 8'o161);
    cyc(1'b1, 1'b1, 8'o101, 3'b111, 16'hF8FF);
    check("R10 other IR bits ignored", 8'o101);
  endtask

  task automatic t_autoinc();
    cyc(1'b1, 1'b1, 8'o170, 3'b100, 16'h0100);
    check("R9 skip to 171", 8'o171);
    cyc(1'b1, 1'b0, 8'o000, 3'b000, '0);
    check("R9 continue 172", 8'o172);
    cyc(1'b1, 1'b1, 8'o170, 3'b100, 16'h0000);
    check("R9 stay at 170", 8'o170);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_increment();
    t_hold();
    t_dispatch();
    t_isolation();
    t_autoinc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule